// File: doc/BRIEF.md
# Platform reset control register

This block is a one-byte register on a simple I/O bus, decoded at port 0xCF9, through which software asks the platform to reset. A byte write with the trigger bit (bit 2) set raises a system reset request; a byte write with the trigger bit clear records the reset-type choice (bit 1) and discards every other bit. Software can read the register back at the same port.

The reset request leaves the block as a pulse of fixed length, which an external reset sequencer acts on. A separate status output tells a state-save mechanism whether the stored byte is nonzero and so worth saving. Accesses to any other port are not claimed: they leave the register alone, drive a zero read bus and keep the hit flag low.

Top module: `rcr_ctl`

## Requirements
- R1: Only accesses whose address equals PORT_ADDR (default 0xCF9) are claimed; a write to any other address leaves the stored byte unchanged.
- R2: A claimed write with bit 2 clear stores bit 1 of the write data in bit 1 and zero in every other bit of the stored byte.
- R3: A claimed write with bit 2 set starts a reset request and leaves the stored byte unchanged, whatever bit 1 holds.
- R4: A claimed read returns the stored byte on io_rdata with io_hit high, one clock edge after the read is sampled; a read and a write in the same cycle return the value from before the write.
- R5: A read of an unclaimed address gives io_rdata = 0 and io_hit = 0 after the next edge.
- R6: Reset clears the stored byte, io_rdata, io_hit, sys_reset_req and save_needed to zero.
- R7: save_needed is high exactly when the stored byte is nonzero, from the edge that stores it.
- R8: sys_reset_req rises on the edge that samples the trigger write and stays high for exactly PULSE_LEN cycles (default 16).
- R9: A trigger write while sys_reset_req is high is ignored: the pulse is not lengthened and no second pulse follows.
- R10: A write with bit 2 set to an unclaimed address raises no reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | ADDR_W | I/O port address |
| io_wr | input | 1 | Byte write strobe, one cycle per access |
| io_rd | input | 1 | Byte read strobe, one cycle per access |
| io_wdata | input | DATA_W | Write data |
| io_rdata | output | DATA_W | Registered read data, zero unless a claimed read |
| io_hit | output | 1 | Registered: the previous cycle's access was claimed |
| sys_reset_req | output | 1 | Reset request pulse, PULSE_LEN cycles long |
| save_needed | output | 1 | Stored byte is nonzero |

## Verification
Every result of this block is due one clock edge after the access is sampled: read data, the hit flag, the new stored value seen through save_needed and the rising of the reset request; the request then falls PULSE_LEN edges after it rose. The bench drives one access per cycle at the falling edge, computes the outputs expected after the following rising edge from the requirements and queues them, and a monitor pops one item two nanoseconds after each rising edge, so every check lands in the cycle its result is due. Idle cycles through the pulse are queued as well, so both the length of the pulse and the ignored second trigger are compared cycle by cycle.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

   // Decoded view of one bus cycle
   typedef struct packed {
      logic wr_hit;   // claimed write
      logic rd_hit;   // claimed read
      logic trig;     // claimed write with the trigger bit set
   } rcr_cmd_t;

   localparam int unsigned RCR_DEF_ADDR_W  = 16;
   localparam int unsigned RCR_DEF_DATA_W  = 8;
   localparam int unsigned RCR_DEF_TRIG    = 2;
   localparam int unsigned RCR_DEF_KEEP    = 1;
   localparam int unsigned RCR_DEF_PULSE   = 16;

endpackage

// File: rtl/rcr_decode.sv
module rcr_decode
   import rcr_pkg::*;
#(
   parameter int unsigned ADDR_W    = RCR_DEF_ADDR_W,
   parameter logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(16'hCF9)
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic              trig_bit,
   output rcr_cmd_t          cmd
);

   logic match;

   always_comb begin
      match       = (addr == PORT_ADDR);
      cmd.wr_hit  = wr & match;
      cmd.rd_hit  = rd & match;
      cmd.trig    = wr & match & trig_bit;
   end

endmodule

// File: rtl/rcr_store.sv
module rcr_store
   import rcr_pkg::*;
#(
   parameter int unsigned DATA_W = RCR_DEF_DATA_W,
   parameter int unsigned KEEP   = RCR_DEF_KEEP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  rcr_cmd_t          cmd,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] stored,
   output logic [DATA_W-1:0] rdata,
   output logic              hit
);

   localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'(1) << KEEP;

   logic [DATA_W-1:0] stored_q;
   logic [DATA_W-1:0] rdata_q;
   logic              hit_q;

   // Stored byte: only the reset-type bit survives a non-trigger write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stored_q <= '0;
      end else if (cmd.wr_hit && !cmd.trig) begin
         stored_q <= wdata & KEEP_MASK;
      end
   end

   // Registered read port; value before any same-cycle write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         hit_q   <= 1'b0;
      end else begin
         rdata_q <= cmd.rd_hit ? stored_q : '0;
         hit_q   <= cmd.rd_hit | cmd.wr_hit;
      end
   end

   assign stored = stored_q;
   assign rdata  = rdata_q;
   assign hit    = hit_q;

endmodule

// File: rtl/rcr_pulse.sv
module rcr_pulse #(
   parameter int unsigned PULSE_LEN = rcr_pkg::RCR_DEF_PULSE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic req
);

   generate
      if (PULSE_LEN == 1) begin : g_single
         logic req_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req_q <= 1'b0;
            else        req_q <= trig & ~req_q;
         end
         assign req = req_q;
      end else begin : g_count
         localparam int unsigned CW = $clog2(PULSE_LEN + 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - CW'(1);
            end else if (trig) begin
               cnt_q <= CW'(PULSE_LEN);
            end
         end
         assign req = (cnt_q != '0);
      end
   endgenerate

endmodule

// File: rtl/rcr_ctl.sv
module rcr_ctl
   import rcr_pkg::*;
#(
   parameter int unsigned ADDR_W    = RCR_DEF_ADDR_W,
   parameter int unsigned DATA_W    = RCR_DEF_DATA_W,
   parameter logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(16'hCF9),
   parameter int unsigned TRIG_BIT  = RCR_DEF_TRIG,
   parameter int unsigned KEEP_BIT  = RCR_DEF_KEEP,
   parameter int unsigned PULSE_LEN = RCR_DEF_PULSE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   output logic              io_hit,
   output logic              sys_reset_req,
   output logic              save_needed
);

   generate
      if (TRIG_BIT >= DATA_W || KEEP_BIT >= DATA_W || TRIG_BIT == KEEP_BIT) begin : g_bad_bits
         initial $error("rcr_ctl: TRIG_BIT/KEEP_BIT out of range or equal");
      end
      if (PULSE_LEN < 1) begin : g_bad_pulse
         initial $error("rcr_ctl: PULSE_LEN must be at least 1");
      end
   endgenerate

   rcr_cmd_t          cmd;
   logic [DATA_W-1:0] stored;

   rcr_decode #(
      .ADDR_W    (ADDR_W),
      .PORT_ADDR (PORT_ADDR)
   ) u_dec (
      .addr     (io_addr),
      .wr       (io_wr),
      .rd       (io_rd),
      .trig_bit (io_wdata[TRIG_BIT]),
      .cmd      (cmd)
   );

   rcr_store #(
      .DATA_W (DATA_W),
      .KEEP   (KEEP_BIT)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmd    (cmd),
      .wdata  (io_wdata),
      .stored (stored),
      .rdata  (io_rdata),
      .hit    (io_hit)
   );

   rcr_pulse #(
      .PULSE_LEN (PULSE_LEN)
   ) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .trig  (cmd.trig),
      .req   (sys_reset_req)
   );

   assign save_needed = |stored;

endmodule

// File: rtl/rcr_ctl_chk.sv
module rcr_ctl_chk #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(16'hCF9),
   parameter int unsigned TRIG_BIT  = 2,
   parameter int unsigned KEEP_BIT  = 1,
   parameter int unsigned PULSE_LEN = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_wr,
   input logic              io_rd,
   input logic [DATA_W-1:0] io_wdata,
   input logic [DATA_W-1:0] io_rdata,
   input logic              io_hit,
   input logic              sys_reset_req,
   input logic              save_needed,
   input logic [DATA_W-1:0] stored
);

   logic at_port;
   assign at_port = (io_addr == PORT_ADDR);

   logic [31:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             run_q <= '0;
      else if (sys_reset_req) run_q <= run_q + 32'd1;
      else                    run_q <= '0;
   end

   // R1
   stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !at_port) |=> $stable(stored));

   // R2
   keep_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && at_port && !io_wdata[TRIG_BIT]) |=> (save_needed == $past(io_wdata[KEEP_BIT])));

   // R3
   trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && at_port && io_wdata[TRIG_BIT]) |=> $stable(stored));

   // R3
   trig_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && at_port && io_wdata[TRIG_BIT] && !sys_reset_req) |=> sys_reset_req);

   // R4
   read_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && at_port) |=> (io_hit && io_rdata == $past(stored)));

   // R5
   unclaimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !((io_rd || io_wr) && at_port) |=> !io_hit);

   // R5
   quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_rd && at_port) |=> (io_rdata == '0));

   // R7
   save_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      save_needed == (stored != '0));

   // R8 R9
   pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sys_reset_req) |-> (run_q == PULSE_LEN));

   // R10
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sys_reset_req && !(io_wr && at_port && io_wdata[TRIG_BIT])) |=> !sys_reset_req);

endmodule

bind rcr_ctl rcr_ctl_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .PORT_ADDR (PORT_ADDR),
   .TRIG_BIT  (TRIG_BIT),
   .KEEP_BIT  (KEEP_BIT),
   .PULSE_LEN (PULSE_LEN)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .io_addr       (io_addr),
   .io_wr         (io_wr),
   .io_rd         (io_rd),
   .io_wdata      (io_wdata),
   .io_rdata      (io_rdata),
   .io_hit        (io_hit),
   .sys_reset_req (sys_reset_req),
   .save_needed   (save_needed),
   .stored        (stored)
);

// File: tb/sim_rcr_ctl.sv
`timescale 1ns/1ps
module sim_rcr_ctl;

   localparam int PULSE = 16;

   typedef struct {
      logic       hit;
      logic [7:0] rdata;
      logic       req;
      logic       save;
      string      tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        io_hit;
   logic        sys_reset_req;
   logic        save_needed;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   exp_t q[$];
   logic [7:0] m_store = '0;
   int         m_cnt = 0;

   always #5 clk = ~clk;

   rcr_ctl u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .io_addr       (io_addr),
      .io_wr         (io_wr),
      .io_rd         (io_rd),
      .io_wdata      (io_wdata),
      .io_rdata      (io_rdata),
      .io_hit        (io_hit),
      .sys_reset_req (sys_reset_req),
      .save_needed   (save_needed)
   );

   // Driver: one bus cycle, expected outputs after the next rising edge
   task automatic step(input logic wr, input logic rd, input logic [15:0] a,
                       input logic [7:0] d, input string tag);
      exp_t e;
      logic hitp;
      @(negedge clk);
      io_wr = wr; io_rd = rd; io_addr = a; io_wdata = d;
      hitp    = (a == 16'hCF9);
      e.hit   = (wr | rd) & hitp;
      e.rdata = (rd & hitp) ? m_store : 8'h00;
      if (m_cnt != 0)                  m_cnt = m_cnt - 1;
      else if (wr && hitp && d[2])     m_cnt = PULSE;
      if (wr && hitp && !d[2])         m_store = d & 8'h02;
      e.req   = (m_cnt != 0);
      e.save  = (m_store != 0);
      e.tag   = tag;
      q.push_back(e);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 16'h0000, 8'h00, tag);
   endtask

   // Monitor
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (io_hit !== e.hit || io_rdata !== e.rdata ||
                sys_reset_req !== e.req || save_needed !== e.save) begin
               n_bad++;
               $display("FAIL %s: got hit=%b rdata=%h req=%b save=%b, exp hit=%b rdata=%h req=%b save=%b",
                        e.tag, io_hit, io_rdata, sys_reset_req, save_needed,
                        e.hit, e.rdata, e.req, e.save);
            end
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R6: reset state
      n_cmp++;
      if (io_hit !== 1'b0 || io_rdata !== 8'h00 || sys_reset_req !== 1'b0 || save_needed !== 1'b0) begin
         n_bad++;
         $display("FAIL R6: got hit=%b rdata=%h req=%b save=%b, exp all zero",
                  io_hit, io_rdata, sys_reset_req, save_needed);
      end
      rst_n = 1'b1;

      step(1'b0, 1'b1, 16'hCF9, 8'h00, "R4 read after reset");
      step(1'b1, 1'b0, 16'hCF9, 8'h02, "R2 store type bit");
      step(1'b0, 1'b1, 16'hCF9, 8'h00, "R4 read type bit");
      step(1'b1, 1'b0, 16'hCF9, 8'hFB, "R2 other bits dropped");
      step(1'b0, 1'b1, 16'hCF9, 8'h00, "R2 read after FB");
      step(1'b1, 1'b1, 16'hCF9, 8'hF9, "R4 read-with-write old value");
      step(1'b0, 1'b1, 16'hCF9, 8'h00, "R7 cleared byte");
      step(1'b1, 1'b0, 16'hCF8, 8'h02, "R1 write other port");
      step(1'b0, 1'b1, 16'hCF9, 8'h00, "R1 byte unchanged");
      step(1'b1, 1'b0, 16'h0CF9 ^ 16'h1000, 8'h02, "R1 high address bit");
      step(1'b0, 1'b1, 16'hCFA, 8'h00, "R5 read other port");
      step(1'b1, 1'b0, 16'hCF8, 8'h04, "R10 trigger other port");
      idle(2, "R10 no request");
      step(1'b1, 1'b0, 16'hCF9, 8'h02, "R2 set type");
      step(1'b1, 1'b0, 16'hCF9, 8'h04, "R3 trigger keeps byte");
      idle(4, "R8 pulse high");
      step(1'b1, 1'b0, 16'hCF9, 8'h06, "R9 trigger during pulse");
      step(1'b0, 1'b1, 16'hCF9, 8'h00, "R3 byte still set");
      idle(PULSE + 2, "R8 R9 pulse length");
      step(1'b1, 1'b0, 16'hCF9, 8'h04, "R3 retrigger after pulse");
      idle(PULSE + 2, "R8 second pulse");
      step(1'b1, 1'b0, 16'hCF9, 8'h00, "R7 clear byte");
      idle(2, "R7 idle");
      @(posedge clk); #3;
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   // Watchdog
   initial begin
      #20000;
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, exp completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule